// File: doc/BRIEF.md
# Backup Charge Termination Timer

This block is the time-based safety net of a fast charger. Three static programming pins choose between two modes. When any pin reads high, the block is in time mode and uses one of seven charge-time limits. When all three pins are low, the timer is off and the charger's temperature window takes over as the backup. A pin left open reads as 1.

In time mode the block counts clock cycles through a prescaler. It does so only while fast charge is in progress. When the programmed number of time units has elapsed, it sets an expiry flag. The flag stays set, and so holds the charger in trickle, until a clear pulse arrives. The system drives that pulse when the battery enters its valid voltage window or when the supply comes up.

Two test switches cut the run time of the long prescaler by raising the count step to a power of two.
- The first switch follows the battery-undervoltage indication.
- The second switch needs undervoltage together with a special test level on the first programming pin, and it replaces the first switch.

Top module: `backup_charge_timer`

## Requirements
- R1: `time_mode` is high exactly when at least one bit of `prog` is 1. `prog[2]` is the third programming pin, `prog[0]` the first, and an open pin reads as 1.
- R2: In normal rate with `fast_en` held high after a clear, `expired` rises after exactly (prog+1) * 2^LOW_W enabled clock edges. Code 7 gives 8 units and code 1 gives 2 units.
- R3: The count advances only on edges where `fast_en` is high. While `fast_en` is low the accumulated count is kept, and expiry needs the same total of enabled edges.
- R4: With `prog` = 000 the timer is held at zero and `expired` reads 0, however long `fast_en` stays high. Expiry is also cleared by the edge after `prog` becomes 000.
- R5: Once set, `expired` stays 1 while `clr` is low and time mode holds, even when `fast_en` drops or the time code changes.
- R6: A one-cycle `clr` clears `expired` and the whole count on the next edge. The following limit is then timed from zero.
- R7: With `uv_test`=1 and `t1_test`=0, each enabled edge advances the prescaler by 2^SW1_STAGES. Expiry then comes after (prog+1) * 2^(LOW_W-SW1_STAGES) edges.
- R8: With `uv_test`=1 and `t1_test`=1, the step is 2^SW2_STAGES, replacing R7. With `uv_test`=0, `t1_test` has no effect and the rate stays normal.
- R9: After `rst_n` is released, `expired` is 0 and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear pulse (battery window entry or supply start) |
| fast_en | input | 1 | Fast charge in progress; timer advances only while high |
| prog | input | 3 | Programming pins, open reads 1; 000 selects temperature mode |
| uv_test | input | 1 | Battery undervoltage indication; enables test rate 1 |
| t1_test | input | 1 | Test level seen on the first programming pin; with uv_test selects test rate 2 |
| expired | output | 1 | Latched time-limit expiry (forces trickle) |
| time_mode | output | 1 | High when the time backup is selected, low for temperature mode |

## Verification
The timer is run to expiry with the lowest code, a middle code and the highest code at normal rate. This separates a limit of (code+1) units from one proportional to the code, or one that is off by one unit. Both test rates are run with different codes, and `t1_test` is also raised without `uv_test`. These runs tell apart a wrong step size, a wrong priority between the switches, and a test level that leaks into normal mode. Further runs pause `fast_en` in mid count and pulse `clr` in mid count; the first proves the count is retained, the second that it restarts from zero. Each expiry edge count is compared with a value computed from the code and rate alone. Holding and clearing of the latch, and quiet operation in temperature mode, are checked at the ports.

// File: rtl/bct_pkg.sv
package bct_pkg;
  localparam int CODE_W = 3;
  typedef enum logic [1:0] {
    RATE_NORM = 2'd0,
    RATE_SW2  = 2'd1,
    RATE_SW1  = 2'd2
  } rate_e;
endpackage

// File: rtl/bct_decode.sv
module bct_decode
  import bct_pkg::*;
(
  input  logic [CODE_W-1:0] prog,
  input  logic              uv_test,
  input  logic              t1_test,
  output logic              time_mode,
  output logic [CODE_W:0]   limit_units,
  output rate_e             rate
);
  localparam logic [CODE_W:0] ONE = (CODE_W+1)'(1);

  always_comb begin
    time_mode   = |prog;
    limit_units = {1'b0, prog} + ONE;
    if (uv_test && t1_test)
      rate = RATE_SW2;
    else if (uv_test)
      rate = RATE_SW1;
    else
      rate = RATE_NORM;
  end
endmodule

// File: rtl/bct_prescale.sv
module bct_prescale
  import bct_pkg::*;
#(
  parameter int LOW_W      = 31,
  parameter int SW1_STAGES = 19,
  parameter int SW2_STAGES = 11
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  en,
  input  rate_e rate,
  output logic  unit_tick
);
  localparam logic [LOW_W:0] STEP_NORM = (LOW_W+1)'(1);
  localparam logic [LOW_W:0] STEP_SW1  = STEP_NORM << SW1_STAGES;
  localparam logic [LOW_W:0] STEP_SW2  = STEP_NORM << SW2_STAGES;

  logic [LOW_W-1:0] low_q;
  logic [LOW_W:0]   step;
  logic [LOW_W:0]   sum;

  always_comb begin
    unique case (rate)
      RATE_SW1: step = STEP_SW1;
      RATE_SW2: step = STEP_SW2;
      default:  step = STEP_NORM;
    endcase
    sum       = {1'b0, low_q} + step;
    unit_tick = en && sum[LOW_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      low_q <= '0;
    else if (clr)
      low_q <= '0;
    else if (en)
      low_q <= sum[LOW_W-1:0];
  end
endmodule

// File: rtl/bct_limit.sv
module bct_limit
  import bct_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            hold,
  input  logic            unit_tick,
  input  logic [CODE_W:0] limit_units,
  output logic [CODE_W:0] unit_cnt,
  output logic            expired
);
  localparam logic [CODE_W:0] ONE = (CODE_W+1)'(1);

  logic [CODE_W:0] next_cnt;
  assign next_cnt = unit_cnt + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_cnt <= '0;
      expired  <= 1'b0;
    end else if (clr || hold) begin
      unit_cnt <= '0;
      expired  <= 1'b0;
    end else if (unit_tick && !expired) begin
      unit_cnt <= next_cnt;
      if (next_cnt == limit_units)
        expired <= 1'b1;
    end
  end
endmodule

// File: rtl/backup_charge_timer.sv
module backup_charge_timer
  import bct_pkg::*;
#(
  parameter int LOW_W      = 31,
  parameter int SW1_STAGES = 19,
  parameter int SW2_STAGES = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fast_en,
  input  logic [CODE_W-1:0] prog,
  input  logic              uv_test,
  input  logic              t1_test,
  output logic              expired,
  output logic              time_mode
);
  logic [CODE_W:0] limit_units;
  logic [CODE_W:0] unit_cnt;
  rate_e           rate;
  logic            unit_tick;
  logic            count_en;
  logic            chain_clr;

  bct_decode u_dec (
    .prog        (prog),
    .uv_test     (uv_test),
    .t1_test     (t1_test),
    .time_mode   (time_mode),
    .limit_units (limit_units),
    .rate        (rate)
  );

  assign count_en  = fast_en && time_mode && !expired;
  assign chain_clr = clr || !time_mode;

  bct_prescale #(
    .LOW_W      (LOW_W),
    .SW1_STAGES (SW1_STAGES),
    .SW2_STAGES (SW2_STAGES)
  ) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (chain_clr),
    .en        (count_en),
    .rate      (rate),
    .unit_tick (unit_tick)
  );

  bct_limit u_lim (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .hold        (!time_mode),
    .unit_tick   (unit_tick),
    .limit_units (limit_units),
    .unit_cnt    (unit_cnt),
    .expired     (expired)
  );
endmodule

// File: rtl/bct_checker.sv
module bct_checker
  import bct_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            clr,
  input logic            fast_en,
  input logic            time_mode,
  input logic            expired,
  input logic [CODE_W:0] unit_cnt
);
  // R4: temperature mode forces the latch low on the next edge
  p_temp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !time_mode |=> !expired);

  // R5: latch holds without a clear
  p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clr && time_mode) |=> expired);

  // R6: clear empties count and latch
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!expired && unit_cnt == '0));

  // R3: no progress without fast charge
  p_pause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_en && !clr && time_mode) |=> $stable(unit_cnt));

  // R2: expiry only follows an enabled edge
  p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> ($past(fast_en) && $past(time_mode)));
endmodule

bind backup_charge_timer bct_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .fast_en   (fast_en),
  .time_mode (time_mode),
  .expired   (expired),
  .unit_cnt  (unit_cnt)
);

// File: tb/backup_charge_timer_test.sv
`timescale 1ns/1ps
module backup_charge_timer_test;
  localparam int LOW = 6;
  localparam int S1  = 4;
  localparam int S2  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       fast_en = 1'b0;
  logic [2:0] prog = 3'b111;
  logic       uv_test = 1'b0;
  logic       t1_test = 1'b0;
  logic       expired;
  logic       time_mode;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    exp_q[$];
  string tag_q[$];
  int    arm_seq  = 0;
  int    done_seq = 0;
  int    mon_cnt  = 0;

  always #2 clk = ~clk;

  backup_charge_timer #(.LOW_W(LOW), .SW1_STAGES(S1), .SW2_STAGES(S2)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fast_en(fast_en), .prog(prog),
    .uv_test(uv_test), .t1_test(t1_test), .expired(expired), .time_mode(time_mode)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: counts enabled edges and compares expiry against the queue
  always @(posedge clk) begin
    #1;
    if (arm_seq != done_seq) begin
      if (fast_en) mon_cnt++;
      if (expired) begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(mon_cnt == e, t, mon_cnt, e);
        done_seq++;
      end
    end else begin
      mon_cnt = 0;
    end
  end

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // shift: 0 normal, S1 test rate 1, S2 test rate 2
  task automatic run_case(input int code, input bit uv, input bit t1, input int shift,
                          input int pause_at, input int clr_at, input string tag);
    int full;
    int guard;
    @(negedge clk);
    fast_en = 1'b0; prog = 3'(code); uv_test = uv; t1_test = t1;
    pulse_clr();
    full = (code + 1) * (1 << (LOW - shift));
    exp_q.push_back(full + clr_at);
    tag_q.push_back(tag);
    arm_seq++;
    fast_en = 1'b1;
    if (pause_at > 0) begin
      repeat (pause_at) @(negedge clk);
      fast_en = 1'b0;
      repeat (40) @(negedge clk);
      check(expired == 1'b0, "R3 paused no expiry", int'(expired), 0);
      fast_en = 1'b1;
    end
    if (clr_at > 0) begin
      repeat (clr_at) @(negedge clk);
      fast_en = 1'b0; clr = 1'b1;
      @(negedge clk);
      clr = 1'b0; fast_en = 1'b1;
    end
    guard = 0;
    while (done_seq != arm_seq && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    if (done_seq != arm_seq) begin
      check(1'b0, {tag, " timeout"}, guard, full);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
      arm_seq = done_seq;
    end
    @(negedge clk);
    fast_en = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(expired == 1'b0, "R9 in reset", int'(expired), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(expired == 1'b0, "R9 after reset", int'(expired), 0);

    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      prog = 3'(c);
      #1;
      check(time_mode == (c != 0), "R1 mode decode", int'(time_mode), int'(c != 0));
    end

    run_case(1, 0, 0, 0,  0,   0, "R2 code1 normal");
    run_case(4, 0, 0, 0,  0,   0, "R2 code4 normal");
    run_case(7, 0, 0, 0,  0,   0, "R2 code7 normal");

    // R5: latch holds after fast_en drops and code changes
    @(negedge clk);
    fast_en = 1'b0; prog = 3'b010;
    repeat (20) @(negedge clk);
    check(expired == 1'b1, "R5 latch hold", int'(expired), 1);
    // R6: clear releases it
    pulse_clr();
    check(expired == 1'b0, "R6 clear latch", int'(expired), 0);

    run_case(2, 0, 0, 0, 70,   0, "R3 pause retains");
    run_case(1, 0, 0, 0,  0, 100, "R6 clear restarts");
    run_case(7, 1, 0, S1, 0,   0, "R7 test1 code7");
    run_case(3, 1, 0, S1, 0,   0, "R7 test1 code3");
    run_case(7, 1, 1, S2, 0,   0, "R8 test2 code7");
    run_case(2, 0, 1, 0,  0,   0, "R8 t1 alone normal");

    // R4: expiry set, then temperature mode clears it
    run_case(3, 1, 0, S1, 0,   0, "R7 test1 before temp");
    @(negedge clk);
    uv_test = 1'b0; prog = 3'b000;
    @(negedge clk);
    check(expired == 1'b0, "R4 temp clears latch", int'(expired), 0);
    fast_en = 1'b1;
    repeat (600) @(negedge clk);
    check(expired == 1'b0, "R4 temp never expires", int'(expired), 0);
    check(time_mode == 1'b0, "R4 temp mode flag", int'(time_mode), 0);
    fast_en = 1'b0;

    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule